// File: doc/BRIEF.md
# Radix-4 Carry-Propagating Sequential Multiplier

The block multiplies an 8-bit unsigned multiplicand by an 8-bit unsigned multiplier over several clock cycles. It scans the multiplier two bits at a time, starting from the least significant pair. Each pair is combined with a carry left over from the previous pair to form a digit value from 0 to 4. That value is then recoded so that each step does at most one addition or one subtraction. The operand of that operation is the multiplicand shifted left by either 2N or 2N+1 places, where N is the step index. Values of 3 and 4 are treated as "four minus something": the step subtracts the difference, or does nothing, and passes a carry of one to the next pair.

A table-select input chooses how a digit value of 2 is handled. Table 0 subtracts the multiplicand shifted by 2N+1 and passes a carry. Table 1 adds the same shifted value and passes no carry. After the four pair steps, one more step folds any leftover carry in as the multiplicand shifted by 8. The computation therefore always takes five steps. The running total is a 32-bit two's-complement value that may go negative partway through. It is visible on the product output while the block works. The final value is the unsigned product.

A user drives the operands and the table select, pulses start for one cycle, and waits for the one-cycle done pulse. The product then stays on its output until the next accepted start.

Top module: `radix4_cp_mult`

## Requirements
- R1: While rst_n is low, product is 0 and done is 0.
- R2: In the done cycle, product equals mcand × mplier as unsigned numbers, zero-extended to 32 bits, for both values of tbl_sel.
- R3: At step N (N = 0..3), let v = multiplier bits [2N+1:2N] + carry-in. The recoding is:
  - v = 0: no change to the total, carry-out 0.
  - v = 1: add mcand<<2N, carry-out 0.
  - v = 3: subtract mcand<<2N, carry-out 1.
  - v = 4: no change to the total, carry-out 1.
- R4: For v = 2, tbl_sel = 0 subtracts mcand<<(2N+1) with carry-out 1, and tbl_sel = 1 adds mcand<<(2N+1) with carry-out 0.
- R5: The carry-in of step 0 is 0. A fifth step (N = 4) adds mcand<<8 when the carry out of step 3 is 1, and otherwise leaves the total unchanged.
- R6: Call the clock edge that samples an accepted start E0. The five steps happen at edges E1..E5. done is 1 only in the cycle that follows E5, and it lasts exactly one cycle.
- R7: A start that arrives while a multiplication is in progress (edges E1..E5) is ignored. mcand, mplier and tbl_sel are sampled only at an accepted start, so changing them during a computation has no effect on it.
- R8: After done, product keeps the final value and done stays 0 until the next accepted start.
- R9: While the block works, product shows the running total after each step in 32-bit two's complement. For mcand 0x5D, mplier 0x4E and tbl_sel 1, the values after E1..E5 are 0x000000BA, 0xFFFFFF46, 0x00000516, 0x00001C56 and 0x00001C56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; taken only when idle |
| tbl_sel | input | 1 | Recoding table for digit value 2 (0: subtract with carry, 1: add) |
| mcand | input | 8 | Unsigned multiplicand |
| mplier | input | 8 | Unsigned multiplier |
| product | output | 32 | Running total while busy; final product from done onward |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
Every result has a fixed due cycle, counted from the edge that samples start. The running total after step k is due just after edge k. done and the final product are due just after the fifth edge, and the held value is due one edge later. The bench drives inputs on falling edges and counts rising edges from start before each sample, so it compares each of these values at the falling edge that follows its due rising edge. It sweeps every multiplier value against a set of multiplicands in both tables and checks all five intermediate totals of each run against a model that uses signed digit weights. Some runs also raise start with different operands partway through, to show that the active computation is not disturbed.

// File: rtl/r4m_pkg.sv
package r4m_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } act_e;

  typedef struct packed {
    act_e act;   // operation on the running total
    logic wide;  // 1: shift by 2N+1, 0: shift by 2N
    logic cout;  // carry passed to the next pair
  } rec_t;

  // Recode one multiplier pair plus carry into a single add/sub action.
  function automatic rec_t recode(input logic [1:0] pair, input logic cin,
                                  input logic tbl);
    rec_t       r;
    logic [2:0] v;
    v = {1'b0, pair} + {2'b00, cin};
    r = '{act: ACT_NONE, wide: 1'b0, cout: 1'b0};
    unique case (v)
      3'd0: r = '{act: ACT_NONE, wide: 1'b0, cout: 1'b0};
      3'd1: r = '{act: ACT_ADD,  wide: 1'b0, cout: 1'b0};
      3'd2: r = tbl ? '{act: ACT_ADD, wide: 1'b1, cout: 1'b0}
                    : '{act: ACT_SUB, wide: 1'b1, cout: 1'b1};
      3'd3: r = '{act: ACT_SUB,  wide: 1'b0, cout: 1'b1};
      3'd4: r = '{act: ACT_NONE, wide: 1'b0, cout: 1'b1};
      default: r = '{act: ACT_NONE, wide: 1'b0, cout: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/r4m_recoder.sv
module r4m_recoder
  import r4m_pkg::*;
(
  input  logic [1:0] pair,
  input  logic       cin,
  input  logic       tbl,
  output act_e       act,
  output logic       wide,
  output logic       cout
);
  rec_t rec;

  always_comb begin
    rec  = recode(pair, cin, tbl);
    act  = rec.act;
    wide = rec.wide;
    cout = rec.cout;
  end
endmodule

// File: rtl/r4m_term_gen.sv
module r4m_term_gen #(
  parameter int A_W = 8,
  parameter int P_W = 32,
  parameter int CW  = 3
) (
  input  logic [A_W-1:0] mcand,
  input  logic [CW-1:0]  step,
  input  logic           wide,
  output logic [P_W-1:0] term
);
  localparam int SW = CW + 1;

  // Place the multiplicand at bit position 2*step + wide.
  function automatic logic [P_W-1:0] place(input logic [A_W-1:0] m,
                                           input logic [SW-1:0] s);
    return {{(P_W-A_W){1'b0}}, m} << s;
  endfunction

  always_comb term = place(mcand, {step, wide});
endmodule

// File: rtl/r4m_accum.sv
module r4m_accum
  import r4m_pkg::*;
#(
  parameter int P_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           en,
  input  act_e           act,
  input  logic [P_W-1:0] term,
  output logic [P_W-1:0] total
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
    end else if (clear) begin
      total <= '0;
    end else if (en) begin
      unique case (act)
        ACT_ADD: total <= total + term;
        ACT_SUB: total <= total - term;
        default: total <= total;
      endcase
    end
  end
endmodule

// File: rtl/r4m_ctrl.sv
module r4m_ctrl #(
  parameter int STEPS = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          last,
  output logic [CW-1:0] cnt,
  output logic          done
);
  // Step index STEPS is the extra carry-fold step.
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS);

  assign accept = start && !busy;
  assign last   = busy && (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/radix4_cp_mult.sv
module radix4_cp_mult
  import r4m_pkg::*;
#(
  parameter int A_W = 8,
  parameter int M_W = 8,
  parameter int P_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           tbl_sel,
  input  logic [A_W-1:0] mcand,
  input  logic [M_W-1:0] mplier,
  output logic [P_W-1:0] product,
  output logic           done
);
  localparam int STEPS = M_W / 2;
  localparam int CW    = $clog2(STEPS + 1);

  // Named internal events, observed by the bound checker.
  logic           accept, busy, last, step_en;
  logic [CW-1:0]  cnt;
  logic [A_W-1:0] mcand_q;
  logic [M_W-1:0] mplier_q;
  logic           tbl_q, carry_q;
  logic [1:0]     pair;
  act_e           rec_act;
  logic           rec_wide, rec_cout;
  logic [P_W-1:0] term, total;

  assign step_en = busy;
  assign pair    = mplier_q[1:0];

  r4m_ctrl #(.STEPS(STEPS), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .busy(busy), .last(last), .cnt(cnt), .done(done)
  );

  // Operand capture; the multiplier shifts so the live pair sits at [1:0].
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      tbl_q    <= 1'b0;
      carry_q  <= 1'b0;
    end else if (accept) begin
      mcand_q  <= mcand;
      mplier_q <= mplier;
      tbl_q    <= tbl_sel;
      carry_q  <= 1'b0;
    end else if (step_en) begin
      mplier_q <= mplier_q >> 2;
      carry_q  <= rec_cout;
    end
  end

  r4m_recoder u_rec (
    .pair(pair), .cin(carry_q), .tbl(tbl_q),
    .act(rec_act), .wide(rec_wide), .cout(rec_cout)
  );

  r4m_term_gen #(.A_W(A_W), .P_W(P_W), .CW(CW)) u_term (
    .mcand(mcand_q), .step(cnt), .wide(rec_wide), .term(term)
  );

  r4m_accum #(.P_W(P_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .en(step_en),
    .act(rec_act), .term(term), .total(total)
  );

  assign product = total;
endmodule

// File: rtl/r4m_checker.sv
module r4m_checker
  import r4m_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int M_W   = 8,
  parameter int P_W   = 32,
  parameter int STEPS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           accept,
  input logic           busy,
  input logic           last,
  input logic           done,
  input logic [1:0]     pair,
  input logic           carry_q,
  input logic           tbl_q,
  input logic [1:0]     act,
  input logic           cout,
  input logic [A_W-1:0] mcand,
  input logic [M_W-1:0] mplier,
  input logic [P_W-1:0] product
);
  logic [P_W-1:0] exp_prod;
  logic [7:0]     steps_seen;
  logic [2:0]     v;

  assign v = {1'b0, pair} + {2'b00, carry_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_prod   <= '0;
      steps_seen <= '0;
    end else if (accept) begin
      exp_prod   <= P_W'(mcand) * P_W'(mplier);
      steps_seen <= '0;
    end else if (busy) begin
      steps_seen <= steps_seen + 8'd1;
    end
  end

  p_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == exp_prod);

  p_digit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && v == 3'd0 |-> act == ACT_NONE && !cout);

  p_digit_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && v == 3'd3 |-> act == ACT_SUB && cout);

  p_digit_four_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && v == 3'd4 |-> act == ACT_NONE && cout);

  p_digit_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && v == 3'd2 |-> (tbl_q ? (act == ACT_ADD && !cout)
                                 : (act == ACT_SUB && cout)));

  p_first_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !carry_q);

  p_carry_fold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last && carry_q |-> act == ACT_ADD);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> steps_seen == 8'(STEPS + 1));

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !last |=> busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !accept |=> $stable(product));
endmodule

bind radix4_cp_mult r4m_checker #(
  .A_W(A_W), .M_W(M_W), .P_W(P_W), .STEPS(STEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
  .last(last), .done(done), .pair(pair), .carry_q(carry_q), .tbl_q(tbl_q),
  .act(rec_act), .cout(rec_cout), .mcand(mcand), .mplier(mplier),
  .product(product)
);

// File: tb/sim_radix4_cp_mult.sv
module sim_radix4_cp_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [7:0]  mcand = '0;
  logic [7:0]  mplier = '0;
  logic [31:0] product;
  logic        done;

  int          n_checks = 0;
  int          n_errors = 0;
  int          cyc = 0;
  logic [31:0] exp_tot [5];

  always #10 clk = ~clk;  // 50 MHz

  radix4_cp_mult u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_sel(tbl_sel),
    .mcand(mcand), .mplier(mplier), .product(product), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model: each pair becomes a signed weight (-2..+2) times mcand<<2N.
  task automatic model(input logic [7:0] a, input logic [7:0] b, input logic t);
    longint acc = 0;
    int     c = 0;
    for (int n = 0; n <= 4; n++) begin
      int pr = (n < 4) ? ((int'(b) >> (2 * n)) & 3) : 0;
      int v  = pr + c;
      int w;
      if (v >= 3 || (v == 2 && t == 1'b0)) begin
        w = v - 4;
        c = 1;
      end else begin
        w = v;
        c = 0;
      end
      acc += longint'(w) * (longint'(a) << (2 * n));
      exp_tot[n] = acc[31:0];
    end
  endtask

  // One multiplication; poke>0 raises start with other operands before edge poke.
  task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                        input logic t, input int poke);
    logic [31:0] full;
    full = 32'(a) * 32'(b);
    @(negedge clk);
    mcand = a; mplier = b; tbl_sel = t; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      if (poke == k) begin
        start = 1'b1; mcand = ~a; mplier = b ^ 8'hA5; tbl_sel = ~t;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      // R3 R4 R5 R9: running total after each step
      check(product == exp_tot[k-1], (poke != 0) ? "R7 step total" : "R9 step total",
            product, exp_tot[k-1]);
      // R6: done only after the fifth step edge
      check(done == (k == 5), "R6 done timing", 32'(done), 32'(k == 5));
      if (k == 5) check(product == full, "R2 product", product, full);
    end
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", 32'(done), 32'd0);
    check(product == full, "R8 product held", product, full);
  endtask

  initial begin
    logic [7:0] alist [12];
    alist = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h5D, 8'h7F,
              8'h80, 8'hAA, 8'hB7, 8'hC3, 8'hFE, 8'hFF};

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(product == 32'd0, "R1 product in reset", product, 32'd0);
    check(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;

    // R9: fixed trace, table 1
    exp_tot = '{32'h000000BA, 32'hFFFFFF46, 32'h00000516, 32'h00001C56, 32'h00001C56};
    run_op(8'h5D, 8'h4E, 1'b1, 0);

    // R2: 0xB7 x 0x5C gives 0x41C4 in both tables
    model(8'hB7, 8'h5C, 1'b0);
    run_op(8'hB7, 8'h5C, 1'b0, 0);
    check(product == 32'h000041C4, "R2 0xB7*0x5C", product, 32'h000041C4);
    model(8'hB7, 8'h5C, 1'b1);
    run_op(8'hB7, 8'h5C, 1'b1, 0);

    // R5: all-ones multiplier leaves a carry to fold in at the fifth step
    model(8'hFF, 8'hFF, 1'b0);
    run_op(8'hFF, 8'hFF, 1'b0, 0);

    // R7: start raised during every step position is ignored
    for (int p = 1; p <= 5; p++) begin
      model(8'h6B, 8'hC6, 1'b0);
      run_op(8'h6B, 8'hC6, 1'b0, p);
    end

    // R2 R3 R4: every multiplier against a set of multiplicands, both tables
    for (int b = 0; b < 256; b++) begin
      for (int i = 0; i < 12; i++) begin
        for (int t = 0; t < 2; t++) begin
          model(alist[i], 8'(b), 1'(t));
          run_op(alist[i], 8'(b), 1'(t), 0);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule